// File: doc/BRIEF.md
# Serial Slave Port with Ready-Request Handshake

This block is the slave end of a four-wire serial link. It moves 24-bit words between an external master and local logic. Every serial input is resampled into the system clock domain. The port recognises clock edges on the resampled serial clock and supports all four combinations of clock idle level and sampling phase. For each word it receives one bit on the master-out line and sends one bit on the master-in line, most significant bit first.

The local side has two streams. The transmit stream has a single holding register. Its ready signal is high only while that register is empty, and the register's contents are consumed when a word starts. The receive stream offers each completed word through a single holding register and keeps it with a stable value until it is accepted. An active-low request output tells the master when the slave can take the next word. It goes inactive as soon as a word's first bit is sampled, and it returns only after the receive holding register has been emptied. Two sticky flags, which clear only on reset, record a received word that had no room and a word that started with no transmit data.

Top module: `spi_word_slave`

## Requirements
- R1: `miso_oe` is high exactly while `ss_n` is low. While `ss_n` is high, toggling `sck` and `mosi` moves no bit and completes no word.
- R2: Words are 24 bits long and travel most significant bit first on both `mosi` and `miso`.
- R3: `cfg_cpol` gives the idle level of `sck`, and the edge that leaves that level is the leading edge. With `cfg_cpha`=0 the slave samples on leading edges and changes `miso` on trailing edges. With `cfg_cpha`=1 it changes `miso` on leading edges and samples on trailing edges.
- R4: With `cfg_cpha`=0, `miso` shows the most significant bit of the pending transmit word as soon as `ss_n` falls, before any `sck` edge. A new word starts only after `ss_n` has gone high and then low again.
- R5: With `cfg_cpha`=1, consecutive words may be sent while `ss_n` stays low.
- R6: `hreq_n` goes high within a few system clocks of the first sampling edge of a word. It stays high while `rx_valid` is high, and it goes low again once no word is in progress and the receive holding register is empty. After reset it is low.
- R7: `rx_valid` rises after the 24th sampling edge. `rx_data` and `rx_valid` hold until a cycle with `rx_valid` and `rx_ready` both high.
- R8: When a word completes while the receive holding register is still full and is not being drained, `rx_data` keeps the old word and `overrun` rises and stays high.
- R9: `tx_ready` is high while the transmit holding register is empty, and a cycle with `tx_valid` and `tx_ready` both high writes it. If the register is empty when a word starts, that word sends all zeros and `underrun` rises and stays high.
- R10: After reset `rx_valid`, `overrun` and `underrun` are 0, `tx_ready` is 1 and `hreq_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Idle level of `sck` |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| sck | input | 1 | Serial clock from master |
| mosi | input | 1 | Serial data from master |
| ss_n | input | 1 | Active-low slave select |
| miso | output | 1 | Serial data to master |
| miso_oe | output | 1 | Output enable for the external `miso` buffer |
| hreq_n | output | 1 | Active-low request: slave ready for the next word |
| tx_data | input | 24 | Word to send |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Transmit holding register is empty |
| rx_data | output | 24 | Last received word |
| rx_valid | output | 1 | `rx_data` holds an unread word |
| rx_ready | input | 1 | Local side accepts `rx_data` |
| overrun | output | 1 | Sticky: a received word was dropped |
| underrun | output | 1 | Sticky: a word started with no transmit data |

## Verification
The hardest case to reach from the ports is a word boundary with no select gap. In phase-1 mode the next word's first leading edge has to find the previous word's transmit load released, a fresh transmit word written, and the request line low again. The bench builds this by holding `ss_n` low after a first word, draining the receive register, refilling the transmit register, and waiting on `hreq_n` as a master would before it clocks the second word. It also reaches the phase-0 counterpart: a word pushed while select stays low after a finished word must remain unconsumed until select toggles. Overrun and underrun are reached by leaving the receive side stalled across two words and by starting a word with nothing pushed.

// File: rtl/sws_pkg.sv
package sws_pkg;
  typedef struct packed {
    logic samp;  // edge on which the slave captures mosi
    logic drv;   // edge on which the slave advances miso
  } sws_edges_t;
endpackage

// File: rtl/sws_sync.sv
module sws_sync #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      chain[g] <= RST_VAL;
      else if (g == 0) chain[g] <= d;
      else             chain[g] <= chain[(g == 0) ? 0 : g-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sws_edge.sv
module sws_edge
  import sws_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck_s,
  input  logic       cpol,
  input  logic       cpha,
  output sws_edges_t ev
);
  logic sck_q;
  logic lvl, lvl_q, lead, trail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_s;
  end

  // Level relative to idle: a rise is the leading edge in every mode.
  assign lvl   = sck_s ^ cpol;
  assign lvl_q = sck_q ^ cpol;
  assign lead  = lvl & ~lvl_q;
  assign trail = ~lvl & lvl_q;

  assign ev.samp = cpha ? trail : lead;
  assign ev.drv  = cpha ? lead  : trail;
endmodule

// File: rtl/sws_shift.sv
module sws_shift
  import sws_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpha,
  input  logic              ss_act,
  input  logic              mosi_s,
  input  sws_edges_t        ev,
  input  logic [WORD_W-1:0] tx_hold,
  input  logic              tx_full,
  output logic              load,
  output logic              first_samp,
  output logic              word_done,
  output logic [WORD_W-1:0] rx_word,
  output logic              loaded,
  output logic              tx_msb,
  output logic              idle
);
  localparam int              CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] rx_sh, tx_sh;
  logic              wait_ss, samp, shift;

  // Phase 0 loads as soon as select is seen; phase 1 loads on the first leading edge.
  assign load       = ss_act && !loaded && (cpha ? ev.drv : !wait_ss);
  assign shift      = ss_act && loaded && ev.drv;
  assign samp       = ss_act && ev.samp;
  assign first_samp = samp && (bit_cnt == '0);
  assign word_done  = samp && (bit_cnt == LAST);
  assign rx_word    = {rx_sh[WORD_W-2:0], mosi_s};
  assign tx_msb     = tx_sh[WORD_W-1];
  assign idle       = (bit_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      loaded  <= 1'b0;
      wait_ss <= 1'b0;
    end else if (!ss_act) begin
      bit_cnt <= '0;
      loaded  <= 1'b0;
      wait_ss <= 1'b0;
    end else begin
      if (samp) begin
        rx_sh   <= rx_word;
        bit_cnt <= word_done ? '0 : bit_cnt + CNT_W'(1);
      end
      if (load) begin
        tx_sh  <= tx_full ? tx_hold : '0;
        loaded <= 1'b1;
      end else if (shift) begin
        tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
      end
      if (word_done) begin
        loaded  <= 1'b0;
        wait_ss <= !cpha;
      end
    end
  end

  a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= LAST);

  // R4: after a phase-0 word, no new load until select is released
  a_r4_no_reload_without_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_ss && ss_act) |=> !loaded);
endmodule

// File: rtl/spi_word_slave.sv
module spi_word_slave
  import sws_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              sck,
  input  logic              mosi,
  input  logic              ss_n,
  output logic              miso,
  output logic              miso_oe,
  output logic              hreq_n,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              overrun,
  output logic              underrun
);
  logic [2:0]        sync_q;
  logic              ss_s, sck_s, mosi_s, ss_act;
  sws_edges_t        ev;
  logic              load, first_samp, word_done, loaded, tx_msb, idle;
  logic [WORD_W-1:0] rx_word, tx_hold;
  logic              tx_full, rx_full, push, pop;

  sws_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ss_n, sck, mosi}), .q(sync_q));

  assign {ss_s, sck_s, mosi_s} = sync_q;
  assign ss_act = !ss_s;

  sws_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .cpol(cfg_cpol), .cpha(cfg_cpha), .ev(ev));

  sws_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cpha(cfg_cpha), .ss_act(ss_act), .mosi_s(mosi_s),
    .ev(ev), .tx_hold(tx_hold), .tx_full(tx_full), .load(load),
    .first_samp(first_samp), .word_done(word_done), .rx_word(rx_word),
    .loaded(loaded), .tx_msb(tx_msb), .idle(idle));

  // Before the load, the first bit comes straight from the holding register.
  assign miso     = loaded ? tx_msb : (tx_full & tx_hold[WORD_W-1]);
  assign miso_oe  = !ss_n;
  assign tx_ready = !tx_full;
  assign rx_valid = rx_full;
  assign push     = tx_valid && !tx_full;
  assign pop      = rx_full && rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full  <= 1'b0;
      tx_hold  <= '0;
      underrun <= 1'b0;
    end else begin
      if (load) begin
        tx_full <= 1'b0;
        if (!tx_full) underrun <= 1'b1;
      end
      if (push) begin
        tx_full <= 1'b1;
        tx_hold <= tx_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full <= 1'b0;
      rx_data <= '0;
      overrun <= 1'b0;
    end else begin
      if (word_done && (!rx_full || pop)) begin
        rx_full <= 1'b1;
        rx_data <= rx_word;
      end else if (pop) begin
        rx_full <= 1'b0;
      end
      if (word_done && rx_full && !pop) overrun <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 hreq_n <= 1'b0;
    else if (first_samp)        hreq_n <= 1'b1;
    else if (idle && !rx_full)  hreq_n <= 1'b0;
  end

  a_r6_busy_after_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
    first_samp |=> hreq_n);

  a_r6_busy_while_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> hreq_n);

  a_r7_rx_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  a_r8_old_word_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && rx_valid && !rx_ready) |=> ($stable(rx_data) && overrun));

  a_r9_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

  a_r9_tx_kept_until_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready && !load) |=> !tx_ready);
endmodule

// File: tb/spi_word_slave_test.sv
module spi_word_slave_test;
  localparam int HALF = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic        sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
  logic        miso, miso_oe, hreq_n, tx_ready, rx_valid, overrun, underrun;
  logic [23:0] tx_data = '0, rx_data;
  logic        tx_valid = 1'b0, rx_ready = 1'b0;
  int          n_chk = 0, n_bad = 0;

  // {cpol, cpha, word from master, word from slave}
  localparam logic [49:0] VEC [8] = '{
    {1'b0, 1'b0, 24'hA5C3F0, 24'h123456},
    {1'b0, 1'b1, 24'h800001, 24'hFEDCBA},
    {1'b1, 1'b0, 24'h5A5A5A, 24'h000001},
    {1'b1, 1'b1, 24'hFFFFFF, 24'h800000},
    {1'b0, 1'b0, 24'h000000, 24'hFFFFFF},
    {1'b0, 1'b1, 24'h369CF0, 24'h0F0F0F},
    {1'b1, 1'b0, 24'hC00003, 24'hAAAAAA},
    {1'b1, 1'b1, 24'h7E8181, 24'h555555}
  };

  always #2 clk = ~clk;

  spi_word_slave uut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .sck(sck), .mosi(mosi), .ss_n(ss_n), .miso(miso), .miso_oe(miso_oe),
    .hreq_n(hreq_n), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .overrun(overrun), .underrun(underrun));

  task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [23:0] d);
    while (!tx_ready) @(negedge clk);
    tx_data  = d;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic pop();
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    wait_clk(3);
  endtask

  task automatic set_mode(input logic pol, input logic pha);
    cfg_cpol = pol;
    cfg_cpha = pha;
    sck      = pol;
    wait_clk(6);
  endtask

  // Master side: one 24-bit word, optionally leaving select low afterwards.
  task automatic xfer(input logic [23:0] mo, output logic [23:0] mi, input bit hold_ss);
    if (ss_n) begin
      ss_n = 1'b0;
      wait_clk(HALF);
    end
    for (int i = 23; i >= 0; i--) begin
      if (!cfg_cpha) begin
        mosi = mo[i];
        wait_clk(HALF);
        sck = ~cfg_cpol;
        mi[i] = miso;
        wait_clk(HALF);
        sck = cfg_cpol;
      end else begin
        sck  = ~cfg_cpol;
        mosi = mo[i];
        wait_clk(HALF);
        sck = cfg_cpol;
        mi[i] = miso;
        wait_clk(HALF);
      end
      if (i == 20) chk(hreq_n == 1'b1, "R6 request dropped mid-word", 24'(hreq_n), 24'd1);
    end
    wait_clk(HALF);
    if (!hold_ss) begin
      ss_n = 1'b1;
      wait_clk(HALF);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [23:0] got, got2;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(2);

    // R10 reset state
    chk(hreq_n == 1'b0,   "R10 hreq_n after reset",   24'(hreq_n),   24'd0);
    chk(rx_valid == 1'b0, "R10 rx_valid after reset", 24'(rx_valid), 24'd0);
    chk(tx_ready == 1'b1, "R10 tx_ready after reset", 24'(tx_ready), 24'd1);
    chk(overrun == 1'b0,  "R10 overrun after reset",  24'(overrun),  24'd0);
    chk(underrun == 1'b0, "R10 underrun after reset", 24'(underrun), 24'd0);
    chk(miso_oe == 1'b0,  "R1 miso_oe with ss_n high", 24'(miso_oe), 24'd0);

    // Table walk: all four modes (R2, R3), stream rules (R6, R7, R9)
    foreach (VEC[k]) begin
      set_mode(VEC[k][49], VEC[k][48]);
      push(VEC[k][23:0]);
      chk(tx_ready == 1'b0, "R9 tx_ready low once written", 24'(tx_ready), 24'd0);
      chk(hreq_n == 1'b0, "R6 request before word", 24'(hreq_n), 24'd0);
      xfer(VEC[k][47:24], got, 1'b0);
      chk(got == VEC[k][23:0], "R2 R3 word seen by master", got, VEC[k][23:0]);
      chk(rx_valid == 1'b1, "R7 rx_valid after word", 24'(rx_valid), 24'd1);
      chk(rx_data == VEC[k][47:24], "R2 R3 word received", rx_data, VEC[k][47:24]);
      chk(tx_ready == 1'b1, "R9 tx consumed by word", 24'(tx_ready), 24'd1);
      wait_clk(7);
      chk(rx_valid && rx_data == VEC[k][47:24], "R7 rx held while stalled", rx_data, VEC[k][47:24]);
      chk(hreq_n == 1'b1, "R6 request high while rx full", 24'(hreq_n), 24'd1);
      pop();
      chk(rx_valid == 1'b0, "R7 rx_valid cleared by accept", 24'(rx_valid), 24'd0);
      chk(hreq_n == 1'b0, "R6 request back after drain", 24'(hreq_n), 24'd0);
    end

    // R1: clocks with select high are ignored
    set_mode(1'b0, 1'b0);
    for (int i = 0; i < 30; i++) begin
      mosi = i[0];
      sck  = ~sck;
      wait_clk(HALF);
    end
    sck = 1'b0;
    wait_clk(HALF);
    chk(miso_oe == 1'b0, "R1 miso_oe stays low", 24'(miso_oe), 24'd0);
    chk(rx_valid == 1'b0, "R1 no word from deselected clocks", 24'(rx_valid), 24'd0);
    chk(hreq_n == 1'b0, "R1 request unchanged when deselected", 24'(hreq_n), 24'd0);
    push(24'h0A0B0C);
    xfer(24'h13579B, got, 1'b0);
    chk(rx_data == 24'h13579B, "R1 no stray bits counted", rx_data, 24'h13579B);
    pop();

    // R4: phase 0, first bit visible at once, boundary only from select
    push(24'hC12345);
    ss_n = 1'b0;
    @(negedge clk);
    chk(miso == 1'b1, "R4 first bit before any clock edge", 24'(miso), 24'd1);
    chk(miso_oe == 1'b1, "R1 miso_oe with ss_n low", 24'(miso_oe), 24'd1);
    xfer(24'h600D01, got, 1'b1);
    chk(got == 24'hC12345, "R4 phase-0 word out", got, 24'hC12345);
    pop();
    push(24'h3C3C3C);
    wait_clk(12);
    chk(tx_ready == 1'b0, "R4 no load without select gap", 24'(tx_ready), 24'd0);
    ss_n = 1'b1;
    wait_clk(HALF);
    xfer(24'h111111, got, 1'b0);
    chk(got == 24'h3C3C3C, "R4 word after select gap", got, 24'h3C3C3C);
    chk(rx_data == 24'h111111, "R4 second word received", rx_data, 24'h111111);
    pop();

    // R5: phase 1, two words with select held low
    set_mode(1'b1, 1'b1);
    push(24'hABCDEF);
    xfer(24'h2468AC, got, 1'b1);
    chk(rx_data == 24'h2468AC, "R5 first of pair received", rx_data, 24'h2468AC);
    pop();
    push(24'h0F1E2D);
    while (hreq_n) @(negedge clk);
    xfer(24'hFDB975, got2, 1'b0);
    chk(got == 24'hABCDEF,  "R5 first of pair sent",  got,  24'hABCDEF);
    chk(got2 == 24'h0F1E2D, "R5 second of pair sent", got2, 24'h0F1E2D);
    chk(rx_data == 24'hFDB975, "R5 second of pair received", rx_data, 24'hFDB975);
    pop();

    // R8: overrun keeps old data
    set_mode(1'b0, 1'b1);
    push(24'h000111);
    xfer(24'h777777, got, 1'b0);
    push(24'h000222);
    xfer(24'h888888, got, 1'b0);
    chk(overrun == 1'b1, "R8 overrun raised", 24'(overrun), 24'd1);
    chk(rx_data == 24'h777777, "R8 old word kept", rx_data, 24'h777777);
    chk(underrun == 1'b0, "R9 no underrun yet", 24'(underrun), 24'd0);
    pop();
    wait_clk(5);
    chk(overrun == 1'b1, "R8 overrun sticky", 24'(overrun), 24'd1);

    // R9: underrun sends zeros
    set_mode(1'b1, 1'b0);
    xfer(24'h999999, got, 1'b0);
    chk(got == 24'h000000, "R9 zeros on empty transmit", got, 24'h000000);
    chk(underrun == 1'b1, "R9 underrun raised", 24'(underrun), 24'd1);
    chk(rx_data == 24'h999999, "R9 receive unaffected by underrun", rx_data, 24'h999999);
    pop();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule